// File: doc/BRIEF.md
# Serial Clock-Calendar and Parameter Memory Slave

This block is the device side of a three-wire serial link to a battery-backed clock chip. The host owns three port bits: an active-low select, a serial clock, and one data line. The data line is driven by the host during command and parameter bytes, and by the device while it returns a read byte. Bytes travel most significant bit first. The first byte of each access is a packed command that names one of four targets: a byte of a 32-bit seconds count, a byte of a small basic parameter memory, a sector of a 256-byte extended parameter memory, or one of two write-only control registers (a test register and a write-protect register).

The seconds count advances by one on each pulse of a 1 Hz tick input. Software treats it as seconds elapsed since the start of 1904; the reset value is a parameter. The 20 basic parameter bytes are the first 20 bytes of the extended array, so both command forms reach the same storage. While the protect flag is set, every write is refused except a write to the protect register itself. A refused or malformed command makes the device ignore the rest of the access until select is released.

All pins are plain level signals sampled in the system clock domain. There is no valid/ready handshake and no back-pressure: the host paces every bit with the serial clock. Persistent backing of the memory and the host's direction control of its port are outside this block. The device only reports, on `sdata_oe`, when it wants to drive the line.

Top module: `rtc_pram_slave`

## Requirements
- R1: While `sel_n` is high the device is idle. Any partly shifted byte and any transaction state are discarded, and `sdata_oe` is 0. After reset, `sdata_oe` and `sdata_out` are 0.
- R2: While the device is not driving, each rising edge of `sclk` shifts `sdata_in` into the receive byte, MSB first. While it is driving, each falling edge of `sclk` puts the next bit of the read byte on `sdata_out`, MSB first. `sdata_oe` is 1 for the whole read phase.
- R3: In a command byte, bit 7 = 1 means read and bit 7 = 0 means write. Every command except the extended one must have bits 1:0 = 01. Any other byte is invalid.
- R4: Commands with bits 6:4 = 000 and bits 1:0 = 01 address seconds byte n = bits 3:2. Byte 0 is the least significant byte of the count. A read returns that byte. A write replaces that byte with the next byte.
- R5: Write command 0x31 (test) takes one data byte and discards it. Write command 0x35 sets the protect flag to bit 7 of its data byte. The read forms 0xB1 and 0xB5 are invalid.
- R6: Pattern z010aa01 addresses basic byte 0x10+aa. Pattern z1aaaa01 addresses basic byte aaaa (0x00 to 0x0F). A read returns that byte. A write stores the next byte there.
- R7: Pattern z0111sss is an extended access to sector sss. The second byte gives an offset in bits 6:2; its bits 7, 1 and 0 are ignored. The memory index is sss*32 + offset. A read then returns that byte. A write stores a third byte there.
- R8: While the protect flag is 1, a write command to any target other than 0x35 changes nothing. Writing 0x35 with bit 7 = 0 clears the flag. Reset clears the flag.
- R9: The seconds count starts at `INIT_SECONDS` (default 0) on reset. It rises by exactly one, with carry across all bytes and wrap from 0xFFFFFFFF to 0, on each cycle in which `tick_1hz` is high.
- R10: After an invalid or refused command, later bytes in the same select window are ignored and the device does not drive. After a read byte is returned, further clock pulses return the same byte again.
- R11: Basic bytes 0x00 to 0x13 are extended indices 0 to 19. A write through either form can be read through the other.
- R12: When a write access completes, the next byte in the same select window is decoded as a new command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all pins are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_n | input | 1 | Active-low chip select from the host |
| sclk | input | 1 | Serial bit clock from the host |
| sdata_in | input | 1 | Serial data from the host |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| sdata_out | output | 1 | Serial read data from the device |
| sdata_oe | output | 1 | High while the device drives the data line |

## Verification
The assertions assume that `sel_n`, `sclk` and `sdata_in` are synchronous to `clk`, and that the host holds each `sclk` level for several cycles, so that every serial edge is seen exactly once. They also assume that the host drives `sdata_in` only while `sdata_oe` is low and waits at least three cycles after the last command bit before it lowers `sclk` for read data. The bench meets these limits by changing pins only on the falling edge of `clk` and by holding every half period of `sclk` for four cycles. It also pulses `tick_1hz` only while no access is in flight, so each seconds check has exactly one expected value.

// File: rtl/rtc_pram_pkg.sv
package rtc_pram_pkg;
  localparam int BYTE_W    = 8;
  localparam int SECT_W    = 3;
  localparam int OFS_W     = 5;
  localparam int SEL_W     = 5;
  localparam int SEC_BYTES = 4;

  typedef enum logic [2:0] {
    K_SEC, K_TEST, K_WP, K_RAM, K_EXT, K_BAD
  } cmd_kind_e;

  typedef enum logic [2:0] {
    PH_CMD, PH_PARAM, PH_DATA, PH_READ, PH_ABORT
  } phase_e;

  typedef struct packed {
    cmd_kind_e        kind;
    logic             rd;
    logic [SEL_W-1:0] sel;
  } cmd_t;
endpackage

// File: rtl/rtc_bit_shifter.sv
module rtc_bit_shifter
  import rtc_pram_pkg::*;
#(
  parameter int W = BYTE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel_n,
  input  logic         sclk,
  input  logic         sdata_in,
  input  logic         drive,
  input  logic         load,
  input  logic [W-1:0] load_byte,
  output logic         byte_valid,
  output logic [W-1:0] rx_byte,
  output logic         sdata_out
);
  localparam int CW = $clog2(W);

  logic          sclk_q;
  logic [CW-1:0] bit_cnt;
  logic [W-1:0]  tx_sr;
  logic          rise, fall;

  assign rise = sclk & ~sclk_q;
  assign fall = ~sclk & sclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q     <= 1'b0;
      bit_cnt    <= '0;
      rx_byte    <= '0;
      byte_valid <= 1'b0;
      tx_sr      <= '0;
      sdata_out  <= 1'b0;
    end else begin
      sclk_q     <= sclk;
      byte_valid <= 1'b0;
      if (sel_n) begin
        bit_cnt <= '0;
      end else if (rise && !drive) begin
        rx_byte <= {rx_byte[W-2:0], sdata_in};
        bit_cnt <= bit_cnt + CW'(1);
        if (bit_cnt == CW'(W-1)) byte_valid <= 1'b1;
      end
      if (load) begin
        tx_sr <= load_byte;
      end else if (fall && drive && !sel_n) begin
        sdata_out <= tx_sr[W-1];
        tx_sr     <= {tx_sr[W-2:0], tx_sr[W-1]};
      end
    end
  end

  AST_BITCNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |=> bit_cnt == '0) else $error("bit count kept across deselect"); // R1
  AST_NO_RX_WHILE_TX: assert property (@(posedge clk) disable iff (!rst_n)
    drive |=> !byte_valid) else $error("byte received while driving"); // R2
endmodule

// File: rtl/rtc_cmd_decode.sv
module rtc_cmd_decode
  import rtc_pram_pkg::*;
(
  input  logic [BYTE_W-1:0] cmd_byte,
  output cmd_t              dec
);
  always_comb begin
    dec.rd   = cmd_byte[7];
    dec.sel  = '0;
    dec.kind = K_BAD;
    if (cmd_byte[6:3] == 4'b0111) begin
      dec.kind = K_EXT;
      dec.sel  = SEL_W'(cmd_byte[2:0]);
    end else if (cmd_byte[1:0] == 2'b01) begin
      if (cmd_byte[6:4] == 3'b000) begin
        dec.kind = K_SEC;
        dec.sel  = SEL_W'(cmd_byte[3:2]);
      end else if (cmd_byte[6:0] == 7'h31) begin
        dec.kind = cmd_byte[7] ? K_BAD : K_TEST;
      end else if (cmd_byte[6:0] == 7'h35) begin
        dec.kind = cmd_byte[7] ? K_BAD : K_WP;
      end else if (cmd_byte[6:4] == 3'b010) begin
        dec.kind = K_RAM;
        dec.sel  = {3'b100, cmd_byte[3:2]};
      end else if (cmd_byte[6]) begin
        dec.kind = K_RAM;
        dec.sel  = {1'b0, cmd_byte[5:2]};
      end
    end
  end
endmodule

// File: rtl/rtc_seconds.sv
module rtc_seconds
  import rtc_pram_pkg::*;
#(
  parameter int              NBYTES = SEC_BYTES,
  parameter int              W      = BYTE_W,
  parameter logic [NBYTES*W-1:0] INIT = '0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tick,
  input  logic                      wr_en,
  input  logic [$clog2(NBYTES)-1:0] wr_sel,
  input  logic [W-1:0]              wr_byte,
  input  logic [$clog2(NBYTES)-1:0] rd_sel,
  output logic [W-1:0]              rd_byte
);
  localparam int CNT_W = NBYTES * W;
  localparam int SW    = $clog2(NBYTES);

  logic [CNT_W-1:0] cnt_q, cnt_inc, cnt_d;

  assign cnt_inc = cnt_q + CNT_W'(tick);

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign cnt_d[b*W +: W] = (wr_en && wr_sel == SW'(b)) ? wr_byte : cnt_inc[b*W +: W];
  end

  assign rd_byte = cnt_q[rd_sel*W +: W];

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= INIT;
    else        cnt_q <= cnt_d;
  end

  AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !wr_en |=> cnt_q == $past(cnt_q) + CNT_W'(1)) else $error("seconds step"); // R9
  AST_SEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !wr_en |=> $stable(cnt_q)) else $error("seconds drift"); // R9
endmodule

// File: rtl/rtc_pram_store.sv
module rtc_pram_store
  import rtc_pram_pkg::*;
#(
  parameter int AW = SECT_W + OFS_W,
  parameter int W  = BYTE_W
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rtc_pram_slave.sv
module rtc_pram_slave
  import rtc_pram_pkg::*;
#(
  parameter int                 SEC_W        = SEC_BYTES * BYTE_W,
  parameter logic [SEC_W-1:0]   INIT_SECONDS = '0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_n,
  input  logic sclk,
  input  logic sdata_in,
  input  logic tick_1hz,
  output logic sdata_out,
  output logic sdata_oe
);
  localparam int AW  = SECT_W + OFS_W;
  localparam int SSW = $clog2(SEC_BYTES);

  phase_e            phase_q, phase_d;
  cmd_t              cmd_q, cmd_d, dec;
  logic [AW-1:0]     idx_q, idx_d, ext_addr, rd_addr, ram_waddr;
  logic              wp_q, wp_d;
  logic              byte_valid, load_out, ram_we, sec_we, drive;
  logic [BYTE_W-1:0] in_byte, load_byte, ram_rdata, ram_wdata, sec_rbyte, sec_wdata;
  logic [SSW-1:0]    sec_wsel;

  assign drive    = (phase_q == PH_READ);
  assign sdata_oe = drive && !sel_n;

  rtc_bit_shifter #(.W(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk), .sdata_in(sdata_in),
    .drive(drive), .load(load_out), .load_byte(load_byte),
    .byte_valid(byte_valid), .rx_byte(in_byte), .sdata_out(sdata_out)
  );

  rtc_cmd_decode u_dec (.cmd_byte(in_byte), .dec(dec));

  rtc_seconds #(.NBYTES(SEC_BYTES), .W(BYTE_W), .INIT(INIT_SECONDS)) u_sec (
    .clk(clk), .rst_n(rst_n), .tick(tick_1hz),
    .wr_en(sec_we), .wr_sel(sec_wsel), .wr_byte(sec_wdata),
    .rd_sel(dec.sel[SSW-1:0]), .rd_byte(sec_rbyte)
  );

  rtc_pram_store #(.AW(AW), .W(BYTE_W)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(rd_addr), .rdata(ram_rdata)
  );

  always_comb begin
    phase_d   = phase_q;
    cmd_d     = cmd_q;
    idx_d     = idx_q;
    wp_d      = wp_q;
    ram_we    = 1'b0;
    ram_waddr = idx_q;
    ram_wdata = in_byte;
    sec_we    = 1'b0;
    sec_wsel  = cmd_q.sel[SSW-1:0];
    sec_wdata = in_byte;
    load_out  = 1'b0;
    ext_addr  = {cmd_q.sel[SECT_W-1:0], in_byte[OFS_W+1:2]};
    rd_addr   = (phase_q == PH_CMD) ? AW'(dec.sel) : ext_addr;
    load_byte = (phase_q == PH_CMD && dec.kind == K_SEC) ? sec_rbyte : ram_rdata;
    if (sel_n) begin
      phase_d = PH_CMD;
    end else if (byte_valid) begin
      case (phase_q)
        PH_CMD: begin
          cmd_d = dec;
          if (dec.kind == K_BAD) begin
            phase_d = PH_ABORT;
          end else if (dec.rd) begin
            if (dec.kind == K_EXT) begin
              phase_d = PH_PARAM;
            end else begin
              load_out = 1'b1;
              phase_d  = PH_READ;
            end
          end else if (wp_q && dec.kind != K_WP) begin
            phase_d = PH_ABORT;
          end else begin
            phase_d = PH_PARAM;
          end
        end
        PH_PARAM: begin
          phase_d = PH_CMD;
          case (cmd_q.kind)
            K_SEC: sec_we = 1'b1;
            K_WP:  wp_d   = in_byte[7];
            K_RAM: begin
              ram_we    = 1'b1;
              ram_waddr = AW'(cmd_q.sel);
            end
            K_EXT: begin
              idx_d = ext_addr;
              if (cmd_q.rd) begin
                load_out = 1'b1;
                phase_d  = PH_READ;
              end else begin
                phase_d = PH_DATA;
              end
            end
            default: ;
          endcase
        end
        PH_DATA: begin
          ram_we  = 1'b1;
          phase_d = PH_CMD;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_CMD;
      cmd_q   <= '{kind: K_BAD, rd: 1'b0, sel: '0};
      idx_q   <= '0;
      wp_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cmd_q   <= cmd_d;
      idx_q   <= idx_d;
      wp_q    <= wp_d;
    end
  end

  AST_IDLE_ON_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |=> phase_q == PH_CMD && !sdata_oe) else $error("busy while deselected"); // R1
  AST_WP_GATES_RAM: assert property (@(posedge clk) disable iff (!rst_n)
    wp_q |-> !ram_we) else $error("memory written while protected"); // R8
  AST_WP_GATES_SEC: assert property (@(posedge clk) disable iff (!rst_n)
    wp_q |-> !sec_we) else $error("seconds written while protected"); // R8
  AST_ABORT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q == PH_ABORT && !sel_n |=> phase_q == PH_ABORT && !sdata_oe) else $error("left abort"); // R10
endmodule

// File: tb/tb_rtc_pram_slave.sv
module tb_rtc_pram_slave;
  localparam int H = 4;
  localparam logic [1:0] OP_W2 = 2'd0, OP_W3 = 2'd1, OP_R1 = 2'd2, OP_R2 = 2'd3;

  typedef struct packed {
    logic [1:0] op;
    logic [7:0] b0, b1, b2, exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VECS [NV] = '{
    '{OP_W2, 8'h01, 8'h11, 8'h00, 8'h00, 4'd4},  // R4 seconds byte 0
    '{OP_W2, 8'h05, 8'h22, 8'h00, 8'h00, 4'd4},
    '{OP_W2, 8'h09, 8'h33, 8'h00, 8'h00, 4'd4},
    '{OP_W2, 8'h0D, 8'h44, 8'h00, 8'h00, 4'd4},
    '{OP_R1, 8'h81, 8'h00, 8'h00, 8'h11, 4'd4},
    '{OP_R1, 8'h85, 8'h00, 8'h00, 8'h22, 4'd4},
    '{OP_R1, 8'h8D, 8'h00, 8'h00, 8'h44, 4'd4},
    '{OP_W2, 8'h41, 8'hA5, 8'h00, 8'h00, 4'd6},  // R6 basic 0x00
    '{OP_W2, 8'h7D, 8'h5A, 8'h00, 8'h00, 4'd6},  // basic 0x0F
    '{OP_W2, 8'h21, 8'hC3, 8'h00, 8'h00, 4'd6},  // basic 0x10
    '{OP_W2, 8'h2D, 8'h3C, 8'h00, 8'h00, 4'd6},  // basic 0x13
    '{OP_R1, 8'hC1, 8'h00, 8'h00, 8'hA5, 4'd6},
    '{OP_R1, 8'hFD, 8'h00, 8'h00, 8'h5A, 4'd6},
    '{OP_R1, 8'hA1, 8'h00, 8'h00, 8'hC3, 4'd6},
    '{OP_R1, 8'hAD, 8'h00, 8'h00, 8'h3C, 4'd6},
    '{OP_R2, 8'hB8, 8'h4C, 8'h00, 8'h3C, 4'd11}, // R11 ext index 19
    '{OP_R2, 8'hB8, 8'h00, 8'h00, 8'hA5, 4'd11},
    '{OP_W3, 8'h3B, 8'h14, 8'h77, 8'h00, 4'd7},  // R7 index 101
    '{OP_R2, 8'hBB, 8'h14, 8'h00, 8'h77, 4'd7},
    '{OP_R2, 8'hBB, 8'h97, 8'h00, 8'h77, 4'd7},  // offset bits 7,1,0 ignored
    '{OP_W3, 8'h38, 8'h08, 8'h99, 8'h00, 4'd11},
    '{OP_R1, 8'hC9, 8'h00, 8'h00, 8'h99, 4'd11},
    '{OP_W3, 8'h3F, 8'h7C, 8'hE1, 8'h00, 4'd7},  // index 255
    '{OP_R2, 8'hBF, 8'h7C, 8'h00, 8'hE1, 4'd7},
    '{OP_W2, 8'h31, 8'hFF, 8'h00, 8'h00, 4'd5},  // R5 test register
    '{OP_R1, 8'hC1, 8'h00, 8'h00, 8'hA5, 4'd5},
    '{OP_W2, 8'h35, 8'h7F, 8'h00, 8'h00, 4'd5},  // bit 7 clear
    '{OP_W2, 8'h45, 8'h6B, 8'h00, 8'h00, 4'd5},
    '{OP_R1, 8'hC5, 8'h00, 8'h00, 8'h6B, 4'd5}
  };

  logic clk = 1'b0, rst_n = 1'b0, sel_n = 1'b1, sclk = 1'b0, sdata_in = 1'b0, tick_1hz = 1'b0;
  logic sdata_out, sdata_oe;
  int total = 0, fails = 0, cyc = 0;
  logic [7:0] rb;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rtc_pram_slave dut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk), .sdata_in(sdata_in),
    .tick_1hz(tick_1hz), .sdata_out(sdata_out), .sdata_oe(sdata_oe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic open_t();
    @(negedge clk); sel_n = 1'b0; sclk = 1'b0; wait_n(H);
  endtask

  task automatic close_t();
    sclk = 1'b0; wait_n(H); sel_n = 1'b1; wait_n(H);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdata_in = b[i]; wait_n(H);
      sclk = 1'b1; wait_n(H);
      sclk = 1'b0;
    end
  endtask

  task automatic recv_byte(output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      wait_n(H);
      r[i] = sdata_out;
      sclk = 1'b1; wait_n(H);
      sclk = 1'b0;
    end
  endtask

  task automatic wr2(input logic [7:0] c, input logic [7:0] d);
    open_t(); send_bits(c, 8); send_bits(d, 8); close_t();
  endtask

  task automatic rd1(input logic [7:0] c, input string req, input logic [7:0] exp);
    logic [7:0] r;
    open_t(); send_bits(c, 8); recv_byte(r); close_t();
    chk(req, r, exp);
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick_1hz = 1'b1; @(negedge clk); tick_1hz = 1'b0;
  endtask

  initial begin : main
    wait_n(5); rst_n = 1'b1; wait_n(2);
    chk("R1 reset oe", {7'd0, sdata_oe}, 8'h00);
    chk("R1 reset out", {7'd0, sdata_out}, 8'h00);
    rd1(8'h81, "R9 init seconds", 8'h00);

    for (int v = 0; v < NV; v++) begin
      string tag;
      tag = $sformatf("R%0d vec %0d", VECS[v].req, v);
      open_t();
      send_bits(VECS[v].b0, 8);
      if (VECS[v].op == OP_W2 || VECS[v].op == OP_W3 || VECS[v].op == OP_R2)
        send_bits(VECS[v].b1, 8);
      if (VECS[v].op == OP_W3) send_bits(VECS[v].b2, 8);
      if (VECS[v].op == OP_R1 || VECS[v].op == OP_R2) begin
        recv_byte(rb);
        chk(tag, rb, VECS[v].exp);
      end
      close_t();
    end

    // R8 protect flag
    wr2(8'h35, 8'h80);
    wr2(8'h41, 8'h00);
    wr2(8'h01, 8'h00);
    open_t(); send_bits(8'h3F, 8); send_bits(8'h7C, 8); send_bits(8'h00, 8); close_t();
    rd1(8'hC1, "R8 basic protected", 8'hA5);
    rd1(8'h81, "R8 seconds protected", 8'h11);
    open_t(); send_bits(8'hBF, 8); send_bits(8'h7C, 8); recv_byte(rb); close_t();
    chk("R8 ext protected", rb, 8'hE1);
    wr2(8'h35, 8'h00);
    wr2(8'h41, 8'h12);
    rd1(8'hC1, "R8 unprotected write", 8'h12);

    // R3 / R10 invalid command aborts the window
    open_t(); send_bits(8'h02, 8); send_bits(8'h41, 8); send_bits(8'h66, 8);
    wait_n(H); chk("R10 no drive after invalid", {7'd0, sdata_oe}, 8'h00); close_t();
    rd1(8'hC1, "R3 invalid ignored", 8'h12);
    open_t(); send_bits(8'h93, 8); wait_n(H);
    chk("R3 bad suffix no drive", {7'd0, sdata_oe}, 8'h00); close_t();
    open_t(); send_bits(8'hB1, 8); wait_n(H);
    chk("R5 test read invalid", {7'd0, sdata_oe}, 8'h00); close_t();

    // R10 repeated read, R2 oe during read
    open_t(); send_bits(8'hC1, 8); wait_n(1);
    chk("R2 oe in read", {7'd0, sdata_oe}, 8'h01);
    recv_byte(rb); chk("R10 first read", rb, 8'h12);
    recv_byte(rb); chk("R10 repeated read", rb, 8'h12);
    close_t();
    chk("R1 oe released", {7'd0, sdata_oe}, 8'h00);

    // R12 chained writes in one window
    open_t(); send_bits(8'h41, 8); send_bits(8'h21, 8);
    send_bits(8'h45, 8); send_bits(8'h22, 8); close_t();
    rd1(8'hC1, "R12 first chained", 8'h21);
    rd1(8'hC5, "R12 second chained", 8'h22);

    // R1 partial byte discarded on deselect
    open_t(); send_bits(8'hF0, 4); close_t();
    rd1(8'hC5, "R1 partial discarded", 8'h22);

    // R9 tick with carry and wrap
    wr2(8'h01, 8'hFF); wr2(8'h05, 8'hFF); wr2(8'h09, 8'hFF); wr2(8'h0D, 8'h00);
    pulse_tick();
    rd1(8'h8D, "R9 carry byte3", 8'h01);
    rd1(8'h81, "R9 carry byte0", 8'h00);
    rd1(8'h85, "R9 carry byte1", 8'h00);
    pulse_tick(); pulse_tick(); pulse_tick();
    rd1(8'h81, "R9 three ticks", 8'h03);
    wr2(8'h01, 8'hFF); wr2(8'h05, 8'hFF); wr2(8'h09, 8'hFF); wr2(8'h0D, 8'hFF);
    pulse_tick();
    rd1(8'h8D, "R9 wrap byte3", 8'h00);
    rd1(8'h81, "R9 wrap byte0", 8'h00);

    // R1 / R8 second reset clears protect and count
    wr2(8'h35, 8'h80);
    @(negedge clk); rst_n = 1'b0; wait_n(3); rst_n = 1'b1; wait_n(2);
    chk("R1 oe after reset", {7'd0, sdata_oe}, 8'h00);
    rd1(8'h81, "R9 reset seconds", 8'h00);
    wr2(8'h41, 8'h5E);
    rd1(8'hC1, "R8 reset clears protect", 8'h5E);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin : watchdog
    wait (cyc >= 150000);
    total++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule